// File: doc/BRIEF.md
# Activity Watchdog with Two-Strike Shutdown

This block watches one activity line driven by a processor or bus and reports when the line stops changing. Each transition on the line starts a new timeout window. If a window runs out with no transition, the block drives two active-low fault signals in a fixed order. First, a pulse output goes low for a fixed number of clocks. A few clocks after the pulse falls, a level output also goes low. The level output stays low until the line changes again.

A built-in two-strike latch samples the level output on every falling edge of the pulse. A single timeout only lowers the level output. A second timeout with no transition in between sets a shutdown request. That request stays set until the next synchronous reset. A disable input models a floating activity line or a failing supply. While disable is high, the block is idle and both fault outputs are high. The timeout length is either a default count or a programmed multiple of a unit count.

Top module: `actwd_top`

## Requirements
- R1: Each transition of `act_i` that reaches the edge detector restarts the window. The next timeout falls exactly one window length after the clock edge that consumes the transition.
- R2: The clock edge that consumes a transition drives `fault_lvl_n` high.
- R3: A window that ends with no transition drives `fault_pls_n` low for exactly `PULSE_TICKS` clocks. The next window starts on the same edge.
- R4: `fault_lvl_n` falls exactly `LAG_TICKS` clocks after `fault_pls_n` falls. It is still high on the edge where the pulse falls.
- R5: Once low, `fault_lvl_n` stays low through later timeouts until a transition arrives.
- R6: On each falling edge of `fault_pls_n`, the block samples `fault_lvl_n`. `shutdown_o` rises only when that sample is low, which means two timeouts in a row with no transition between them.
- R7: Once set, `shutdown_o` stays high through activity and through disable. Only `rst` clears it.
- R8: While `dis_i` is high, from the next clock on, both fault outputs are high, no pulse occurs, and transitions have no effect.
- R9: After `dis_i` falls, the first timeout comes exactly one window after the last edge that sampled `dis_i` high. That timeout does not set `shutdown_o`.
- R10: When `tsel_i` is 0, the window is `DEF_TICKS` clocks. When `tsel_i` is n (nonzero), the window is n*`UNIT_TICKS` clocks.
- R11: `act_i` passes through a two-flop synchronizer. A change driven just after edge k is consumed on edge k+3, and not earlier.
- R12: After reset, `fault_lvl_n`=1, `fault_pls_n`=1 and `shutdown_o`=0. The first window counts from the last edge where `rst` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| act_i | input | 1 | Activity line (asynchronous) |
| dis_i | input | 1 | Disable: watchdog idle, outputs high |
| tsel_i | input | SEL_W | Timeout select: 0 selects the default, n selects n times the unit |
| fault_lvl_n | output | 1 | Active-low fault level |
| fault_pls_n | output | 1 | Active-low fault pulse |
| shutdown_o | output | 1 | Latched shutdown request after two timeouts in a row |

## Verification
A wrong window count appears at `fault_pls_n` within one window length, because the pulse falls one cycle early or one cycle late. A bad pulse or lag counter shows up on the pulse's rising edge or on the fall of `fault_lvl_n`, at most `PULSE_TICKS` clocks after the timeout. A two-strike flag that samples the wrong value shows up as a `shutdown_o` change on the second timeout, or as a shutdown that is missing there. A missing synchronizer stage moves the recovery of `fault_lvl_n` by one clock.

// File: rtl/actwd_pkg.sv
package actwd_pkg;

   // Larger of two counts, used to size the window counter.
   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Window length in clocks for a given select value.
   function automatic int unsigned window_len(input int unsigned sel,
                                              input int unsigned def_ticks,
                                              input int unsigned unit_ticks);
      return (sel == 0) ? def_ticks : sel * unit_ticks;
   endfunction

endpackage

// File: rtl/actwd_sync_edge.sv
module actwd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic edge_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   // A change on the synchronized line is one activity event.
   assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/actwd_window_timer.sv
module actwd_window_timer #(
   parameter int DEF_TICKS  = 32000,
   parameter int UNIT_TICKS = 1000,
   parameter int SEL_W      = 7,
   parameter int CNT_W      = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold_i,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             at_end;

   assign lim = CNT_W'(actwd_pkg::window_len(int'(unsigned'(sel_i)),
                                             DEF_TICKS, UNIT_TICKS));

   // Compare with >= so a live change of select cannot skip the end.
   assign at_end   = (cnt_q >= (lim - CNT_W'(1)));
   assign expire_o = at_end && !hold_i && !restart_i;

   always_ff @(posedge clk) begin
      if (rst || hold_i || restart_i) begin
         cnt_q <= '0;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/actwd_fault_seq.sv
module actwd_fault_seq #(
   parameter int PULSE_TICKS = 20,
   parameter int LAG_TICKS   = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic dis_i,
   input  logic activity_i,
   input  logic expire_i,
   output logic lvl_n_o,
   output logic pls_n_o,
   output logic shut_o
);

   localparam int PW = $clog2(PULSE_TICKS + 1);
   localparam int LW = $clog2(LAG_TICKS + 1);

   logic [PW-1:0] pcnt_q;
   logic [LW-1:0] lag_q;
   logic          lvl_n_q;
   logic          pls_n_q;
   logic          shut_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt_q  <= '0;
         lag_q   <= '0;
         lvl_n_q <= 1'b1;
         pls_n_q <= 1'b1;
         shut_q  <= 1'b0;
      end else if (dis_i) begin
         pcnt_q  <= '0;
         lag_q   <= '0;
         lvl_n_q <= 1'b1;
         pls_n_q <= 1'b1;
      end else begin
         // pulse generator
         if (expire_i) begin
            pls_n_q <= 1'b0;
            pcnt_q  <= PW'(PULSE_TICKS);
         end else if (pcnt_q != '0) begin
            pcnt_q <= pcnt_q - PW'(1);
            if (pcnt_q == PW'(1)) pls_n_q <= 1'b1;
         end

         // delayed level output; activity cancels a pending fall
         if (activity_i) begin
            lvl_n_q <= 1'b1;
            lag_q   <= '0;
         end else if (expire_i) begin
            lag_q <= LW'(LAG_TICKS);
         end else if (lag_q != '0) begin
            lag_q <= lag_q - LW'(1);
            if (lag_q == LW'(1)) lvl_n_q <= 1'b0;
         end

         // two-strike latch: sample level at the pulse fall
         if (expire_i && !lvl_n_q) shut_q <= 1'b1;
      end
   end

   assign lvl_n_o = lvl_n_q;
   assign pls_n_o = pls_n_q;
   assign shut_o  = shut_q;

endmodule

// File: rtl/actwd_top.sv
module actwd_top #(
   parameter int SYNC_STAGES = 2,
   parameter int DEF_TICKS   = 32000,
   parameter int UNIT_TICKS  = 1000,
   parameter int SEL_W       = 7,
   parameter int PULSE_TICKS = 20,
   parameter int LAG_TICKS   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_i,
   input  logic             dis_i,
   input  logic [SEL_W-1:0] tsel_i,
   output logic             fault_lvl_n,
   output logic             fault_pls_n,
   output logic             shutdown_o
);

   localparam int unsigned MAX_WIN =
      actwd_pkg::umax(DEF_TICKS, ((1 << SEL_W) - 1) * UNIT_TICKS);
   localparam int CNT_W = $clog2(MAX_WIN + 1);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel
      $error("SEL_W must be within 1..16");
   end
   if (LAG_TICKS < 1) begin : g_bad_lag
      $error("LAG_TICKS must be at least 1");
   end
   if (PULSE_TICKS <= LAG_TICKS) begin : g_bad_pulse
      $error("PULSE_TICKS must exceed LAG_TICKS");
   end
   if (UNIT_TICKS <= PULSE_TICKS || DEF_TICKS <= PULSE_TICKS) begin : g_bad_win
      $error("every window must be longer than the pulse");
   end

   logic act_edge;
   logic win_expire;

   actwd_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d_i    (act_i),
      .edge_o (act_edge)
   );

   actwd_window_timer #(
      .DEF_TICKS  (DEF_TICKS),
      .UNIT_TICKS (UNIT_TICKS),
      .SEL_W      (SEL_W),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .hold_i    (dis_i),
      .restart_i (act_edge),
      .sel_i     (tsel_i),
      .expire_o  (win_expire)
   );

   actwd_fault_seq #(
      .PULSE_TICKS (PULSE_TICKS),
      .LAG_TICKS   (LAG_TICKS)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .dis_i      (dis_i),
      .activity_i (act_edge),
      .expire_i   (win_expire),
      .lvl_n_o    (fault_lvl_n),
      .pls_n_o    (fault_pls_n),
      .shut_o     (shutdown_o)
   );

endmodule

// File: rtl/actwd_chk.sv
module actwd_chk #(
   parameter int PULSE_TICKS = 20
) (
   input logic clk,
   input logic rst,
   input logic dis_i,
   input logic act_edge,
   input logic fault_lvl_n,
   input logic fault_pls_n,
   input logic shutdown_o
);

   // counts low cycles of the pulse output
   logic [31:0] low_cnt;

   always_ff @(posedge clk) begin
      if (rst || fault_pls_n) low_cnt <= '0;
      else                    low_cnt <= low_cnt + 32'd1;
   end

   // R2: a consumed transition raises the level output
   a_r2_edge_raises_level: assert property (@(posedge clk) disable iff (rst)
      act_edge |=> fault_lvl_n);

   // R3: an undisturbed pulse lasts exactly PULSE_TICKS clocks
   a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
      ($rose(fault_pls_n) && !$past(dis_i)) |-> (low_cnt == 32'(PULSE_TICKS)));

   // R4: the level output only falls while the pulse is low
   a_r4_level_after_pulse: assert property (@(posedge clk) disable iff (rst)
      $fell(fault_lvl_n) |-> !fault_pls_n);

   // R6: shutdown rises only at a pulse fall that saw the level low
   a_r6_second_strike: assert property (@(posedge clk) disable iff (rst)
      $rose(shutdown_o) |-> ($fell(fault_pls_n) && !$past(fault_lvl_n)));

   // R7: shutdown is sticky until reset
   a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (rst)
      shutdown_o |=> shutdown_o);

   // R8: disable forces both fault outputs high
   a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
      dis_i |=> (fault_lvl_n && fault_pls_n));

endmodule

bind actwd_top actwd_chk #(
   .PULSE_TICKS (PULSE_TICKS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .dis_i       (dis_i),
   .act_edge    (act_edge),
   .fault_lvl_n (fault_lvl_n),
   .fault_pls_n (fault_pls_n),
   .shutdown_o  (shutdown_o)
);

// File: tb/sim_actwd_top.sv
module sim_actwd_top;

   localparam int DEF = 40;
   localparam int UNIT = 8;
   localparam int SW = 3;
   localparam int P = 5;
   localparam int LAG = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          act = 1'b0;
   logic          dis = 1'b0;
   logic [SW-1:0] tsel = '0;
   wire           lvl_n;
   wire           pls_n;
   wire           shut;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   actwd_top #(
      .SYNC_STAGES (2),
      .DEF_TICKS   (DEF),
      .UNIT_TICKS  (UNIT),
      .SEL_W       (SW),
      .PULSE_TICKS (P),
      .LAG_TICKS   (LAG)
   ) u0 (
      .clk         (clk),
      .rst         (rst),
      .act_i       (act),
      .dis_i       (dis),
      .tsel_i      (tsel),
      .fault_lvl_n (lvl_n),
      .fault_pls_n (pls_n),
      .shutdown_o  (shut)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic actv, input logic expv);
      n_chk++;
      if (actv !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, actv, expv);
      end
   endtask

   // leaves the bench at the negedge just after the last reset edge
   task automatic reset_dut;
      @(negedge clk);
      rst = 1'b1;
      step(2);
      rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int win;
      bit ok;

      // R10 / R3 / R4 / R5 / R6 / R12: sweep over every select value
      for (int s = 0; s < (1 << SW); s++) begin
         tsel = SW'(s);
         win = (s == 0) ? DEF : s * UNIT;
         reset_dut;
         check("R12", "level after reset", lvl_n, 1'b1);
         check("R12", "pulse after reset", pls_n, 1'b1);
         check("R12", "shutdown after reset", shut, 1'b0);
         step(win - 1);
         check("R10", "pulse one clock before window end", pls_n, 1'b1);
         step(1);
         check("R10", "pulse low at window end", pls_n, 1'b0);
         check("R4", "level high at pulse fall", lvl_n, 1'b1);
         step(LAG - 1);
         check("R4", "level before lag expires", lvl_n, 1'b1);
         step(1);
         check("R4", "level low after lag", lvl_n, 1'b0);
         step(P - LAG - 1);
         check("R3", "pulse still low on last pulse clock", pls_n, 1'b0);
         step(1);
         check("R3", "pulse released", pls_n, 1'b1);
         check("R6", "no shutdown after first timeout", shut, 1'b0);
         step(win - P);
         check("R5", "level still low at second timeout", lvl_n, 1'b0);
         check("R6", "shutdown on second timeout", shut, 1'b1);
         check("R3", "second pulse low", pls_n, 1'b0);
      end

      // R1 / R11: regular activity keeps both outputs high
      tsel = '0;
      reset_dut;
      ok = 1'b1;
      for (int j = 0; j < 8; j++) begin
         for (int c = 0; c < 20; c++) begin
            step(1);
            if (lvl_n !== 1'b1 || pls_n !== 1'b1) ok = 1'b0;
         end
         act = ~act;
      end
      check("R1", "outputs high under steady activity", ok, 1'b1);
      step(3 + DEF - 1);
      check("R1", "no pulse before restarted window ends", pls_n, 1'b1);
      step(1);
      check("R1", "pulse one window after consumed edge", pls_n, 1'b0);
      step(LAG);
      check("R4", "level low after lag", lvl_n, 1'b0);
      step(10);
      check("R5", "level stays low without activity", lvl_n, 1'b0);
      act = ~act;
      step(2);
      check("R11", "level still low before sync latency", lvl_n, 1'b0);
      step(1);
      check("R2", "transition raises level", lvl_n, 1'b1);
      step(DEF);
      check("R6", "timeout after recovery does not shut down", shut, 1'b0);
      check("R4", "level high when new pulse falls", lvl_n, 1'b1);
      check("R3", "pulse low after recovery window", pls_n, 1'b0);
      step(LAG);
      check("R4", "level low again", lvl_n, 1'b0);
      step(DEF - LAG);
      check("R6", "second consecutive timeout shuts down", shut, 1'b1);
      act = ~act;
      step(8);
      check("R7", "activity keeps shutdown", shut, 1'b1);
      check("R2", "activity raises level after shutdown", lvl_n, 1'b1);
      dis = 1'b1;
      step(5);
      check("R7", "disable keeps shutdown", shut, 1'b1);
      dis = 1'b0;
      reset_dut;
      check("R7", "reset clears shutdown", shut, 1'b0);

      // R8 / R9: disable during a fault, then release
      step(DEF + LAG);
      check("R8", "level low before disable", lvl_n, 1'b0);
      check("R8", "pulse low before disable", pls_n, 1'b0);
      dis = 1'b1;
      step(1);
      check("R8", "disable raises level", lvl_n, 1'b1);
      check("R8", "disable ends pulse", pls_n, 1'b1);
      ok = 1'b1;
      for (int i = 0; i < 3 * DEF; i++) begin
         if (i % 7 == 0 && i < 100) act = ~act;
         step(1);
         if (lvl_n !== 1'b1 || pls_n !== 1'b1) ok = 1'b0;
      end
      check("R8", "outputs high and no pulses while disabled", ok, 1'b1);
      check("R8", "no shutdown while disabled", shut, 1'b0);
      dis = 1'b0;
      step(DEF - 1);
      check("R9", "no pulse before fresh window ends", pls_n, 1'b1);
      step(1);
      check("R9", "pulse one window after release", pls_n, 1'b0);
      check("R9", "first timeout after release no shutdown", shut, 1'b0);
      check("R9", "level high at that pulse fall", lvl_n, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule